// File: doc/BRIEF.md
# Page Write Buffer and Programming Sequencer

This block sits behind the command decoder of a serial non-volatile memory. Once a page-program command and its start address have been decoded, the decoder loads the address and then streams the incoming data bytes into the block. The block keeps them in a page-sized buffer. The byte offset inside the page advances after every byte and wraps at the page edge, so the upper address bits never change. For each byte it also records whether the protection unit reported that address as writable.

The command ends when chip select rises. The decoder signals this with a one-cycle event and a flag that says whether the rise fell on a byte boundary. If that rise is aligned, the write-enable latch is set and at least one byte is buffered, the block goes busy for a fixed number of clock cycles, which stands in for the programming time. During the first page-length cycles of that window it drains the buffer into the array model, one byte per cycle. When the window closes it pulses a clear request to the write-enable latch.

Any other rise of chip select throws the buffered bytes away. While busy, the byte stream is back-pressured and all other inputs are ignored. The data stream is valid/ready. A byte transfers on a clock edge where `byte_valid` and `byte_ready` are both 1. `byte_ready` is held low for the whole busy window, and a byte offered then is not taken; the source must keep `byte_valid` and `byte_data` steady until it is accepted, or drop the byte.

Top module: `pgwr_engine`

## Requirements
- R1: After reset, `busy`=0, `byte_ready`=1, `arr_we`=0, `wel_clr`=0, and every array location reads 0.
- R2: Data byte k after an address load at A (page base = A with its low 5 bits cleared, PAGE_BYTES=32) is committed to page base + ((A[4:0]+k) mod 32). `next_addr` keeps the upper bits of A fixed.
- R3: When more than 32 bytes are sent, a later byte for the same page slot replaces the earlier one, and each slot is programmed at most once.
- R4: A programming cycle starts only on a `cs_rise` with `cs_aligned`=1, `wel`=1 and at least one byte buffered. Otherwise `busy` stays 0 and the array is unchanged.
- R5: With `wel`=0 at `cs_rise`, the buffered bytes are discarded, nothing is written and `wel_clr` is not pulsed.
- R6: `busy` is 1 for exactly CYCLE_CLKS cycles, starting the cycle after the `cs_rise` edge. `byte_ready` is 0 the whole time. Byte strobes, address loads and `cs_rise` during busy are ignored: they cause no restart and leave no buffered byte.
- R7: `wel_clr` is a one-cycle pulse in the first cycle `busy` is 0 after a programming cycle, and is 0 at all other times.
- R8: Only slots that received a byte while `addr_writable` was 1 are programmed. There is exactly one `arr_we` per such slot.
- R9: `arr_we` is 1 only while `busy` is 1.
- R10: A `cs_rise` that does not start a cycle clears the buffered bytes but keeps the page base and the current offset. Later bytes continue from that offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Load start address (ignored while busy) |
| addr_start | input | ADDR_W | Start address of the page write |
| byte_valid | input | 1 | Data byte offered |
| byte_ready | output | 1 | Data byte can be accepted (0 while busy) |
| byte_data | input | DATA_W | Data byte |
| next_addr | output | ADDR_W | Address the next accepted byte will land at |
| addr_writable | input | 1 | Protection verdict for `next_addr` |
| cs_rise | input | 1 | One-cycle chip-select rise event |
| cs_aligned | input | 1 | The rise came directly after a complete byte |
| wel | input | 1 | Write-enable latch state |
| busy | output | 1 | Programming cycle in progress |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| wel_clr | output | 1 | Request to clear the write-enable latch |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array read data (combinational) |

## Verification
The bench drives every input on a falling edge and samples one falling edge later. A `cs_rise` that starts a cycle therefore shows `busy`=1 at the very next sample. The bench then counts `busy` samples, expecting exactly CYCLE_CLKS, and counts `arr_we` samples, which can appear only in the first 32 of those.

`wel_clr` is checked at the first sample where `busy` is 0 and again one sample later, to confirm it is a single-cycle pulse. Array contents are read back through the combinational read port only after `busy` has fallen, and are compared with a shadow page model built from the requirements.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PROG = 1'b1
  } pgwr_state_e;
endpackage

// File: rtl/pgwr_buffer.sv
// Page buffer: page base, wrapping offset, per-slot data, received and writable flags.
module pgwr_buffer #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [ADDR_W-1:0]     load_addr,
  input  logic                  push,
  input  logic [DATA_W-1:0]     push_data,
  input  logic                  push_ok,
  input  logic                  clear,
  input  logic [$clog2(PAGE_BYTES)-1:0] scan_slot,
  output logic [ADDR_W-1:0]     next_addr,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_base,
  output logic [DATA_W-1:0]     scan_data,
  output logic                  scan_vld,
  output logic                  scan_ok,
  output logic                  any_vld
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int BASE_W = ADDR_W - OFF_W;

  logic [BASE_W-1:0]     base_q;
  logic [OFF_W-1:0]      off_q;
  logic [PAGE_BYTES-1:0] vld_q;
  logic [PAGE_BYTES-1:0] ok_q;
  logic [DATA_W-1:0]     slot_data [PAGE_BYTES];
  logic                  take;

  assign take = push && !load && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      off_q  <= '0;
      vld_q  <= '0;
      ok_q   <= '0;
    end else if (load) begin
      base_q <= load_addr[ADDR_W-1:OFF_W];
      off_q  <= load_addr[OFF_W-1:0];
      vld_q  <= '0;
    end else if (clear) begin
      vld_q  <= '0;
    end else if (push) begin
      vld_q[off_q] <= 1'b1;
      ok_q[off_q]  <= push_ok;
      off_q        <= off_q + 1'b1;
    end
  end

  // One data register per page slot.
  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (take && off_q == OFF_W'(i)) q <= push_data;
    end
    assign slot_data[i] = q;
  end

  assign next_addr = {base_q, off_q};
  assign page_base = base_q;
  assign scan_data = slot_data[scan_slot];
  assign scan_vld  = vld_q[scan_slot];
  assign scan_ok   = ok_q[scan_slot];
  assign any_vld   = |vld_q;
endmodule

// File: rtl/pgwr_seq.sv
// Cycle sequencer: start decision, timed busy window, slot scan, latch-clear pulse.
module pgwr_seq
  import pgwr_pkg::*;
#(
  parameter int PAGE_BYTES = 32,
  parameter int CYCLE_CLKS = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cs_rise,
  input  logic                          cs_aligned,
  input  logic                          wel,
  input  logic                          any_vld,
  output logic                          busy,
  output logic                          scan_active,
  output logic [$clog2(PAGE_BYTES)-1:0] scan_slot,
  output logic                          clear,
  output logic                          wel_clr
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int CNT_W = $clog2(CYCLE_CLKS + 1);

  pgwr_state_e      state_q;
  logic [CNT_W-1:0] tick_q;
  logic             start;
  logic             last;
  logic             clr_q;

  assign start = (state_q == ST_IDLE) && cs_rise && cs_aligned && wel && any_vld;
  assign last  = (state_q == ST_PROG) && (tick_q == CNT_W'(CYCLE_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tick_q  <= '0;
      clr_q   <= 1'b0;
    end else begin
      clr_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_PROG;
            tick_q  <= '0;
          end
        end
        ST_PROG: begin
          if (last) begin
            state_q <= ST_IDLE;
            tick_q  <= '0;
            clr_q   <= 1'b1;
          end else begin
            tick_q <= tick_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state_q == ST_PROG);
  assign scan_active = busy && (tick_q < CNT_W'(PAGE_BYTES));
  assign scan_slot   = tick_q[OFF_W-1:0];
  assign clear       = ((state_q == ST_IDLE) && cs_rise && !start) || last;
  assign wel_clr     = clr_q;
endmodule

// File: rtl/pgwr_array.sv
// Behavioural byte array standing in for the non-volatile cells.
module pgwr_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pgwr_engine.sv
module pgwr_engine #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32,
  parameter int CYCLE_CLKS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_start,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [DATA_W-1:0] byte_data,
  output logic [ADDR_W-1:0] next_addr,
  input  logic              addr_writable,
  input  logic              cs_rise,
  input  logic              cs_aligned,
  input  logic              wel,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              wel_clr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int BASE_W = ADDR_W - OFF_W;

  logic              push, load, clear, any_vld;
  logic              scan_active, scan_vld, scan_ok;
  logic [OFF_W-1:0]  scan_slot;
  logic [BASE_W-1:0] page_base;
  logic [DATA_W-1:0] scan_data;

  assign byte_ready = !busy;
  assign push       = byte_valid && byte_ready;
  assign load       = addr_load && !busy;

  pgwr_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .load(load), .load_addr(addr_start),
    .push(push), .push_data(byte_data), .push_ok(addr_writable), .clear(clear),
    .scan_slot(scan_slot), .next_addr(next_addr), .page_base(page_base),
    .scan_data(scan_data), .scan_vld(scan_vld), .scan_ok(scan_ok), .any_vld(any_vld)
  );

  pgwr_seq #(.PAGE_BYTES(PAGE_BYTES), .CYCLE_CLKS(CYCLE_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .cs_aligned(cs_aligned), .wel(wel),
    .any_vld(any_vld), .busy(busy), .scan_active(scan_active), .scan_slot(scan_slot),
    .clear(clear), .wel_clr(wel_clr)
  );

  assign arr_we    = scan_active && scan_vld && scan_ok;
  assign arr_addr  = {page_base, scan_slot};
  assign arr_wdata = scan_data;

  pgwr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr(arr_addr), .wdata(arr_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/pgwr_checker.sv
module pgwr_checker #(
  parameter int CYCLE_CLKS = 64
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic byte_ready,
  input logic arr_we,
  input logic wel_clr,
  input logic cs_rise,
  input logic cs_aligned,
  input logic wel
);
  localparam int CNT_W = $clog2(CYCLE_CLKS + 1);
  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else        busy_cnt <= busy ? busy_cnt + 1'b1 : '0;
  end

  p_no_early_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !busy && !cs_aligned) |=> !busy);
  p_no_start_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !busy && !wel) |=> !busy);
  p_busy_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_cnt < CNT_W'(CYCLE_CLKS)));
  p_busy_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == CNT_W'(CYCLE_CLKS)));
  p_backpressure_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !byte_ready);
  p_clr_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> wel_clr);
  p_clr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !wel_clr);
  p_clr_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> $past(busy));
  p_we_in_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);
endmodule

bind pgwr_engine pgwr_checker #(.CYCLE_CLKS(CYCLE_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .byte_ready(byte_ready), .arr_we(arr_we),
  .wel_clr(wel_clr), .cs_rise(cs_rise), .cs_aligned(cs_aligned), .wel(wel)
);

// File: tb/sim_pgwr_engine.sv
module sim_pgwr_engine;
  localparam int CYC = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_load = 1'b0;
  logic [9:0] addr_start = '0;
  logic       byte_valid = 1'b0;
  logic       byte_ready;
  logic [7:0] byte_data = '0;
  logic [9:0] next_addr;
  logic       addr_writable;
  logic       cs_rise = 1'b0, cs_aligned = 1'b0, wel = 1'b0;
  logic       busy, arr_we, wel_clr;
  logic [9:0] arr_addr;
  logic [7:0] arr_wdata;
  logic [9:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       prot_on = 1'b0;

  int checks = 0, fails = 0, cyc = 0, stray = 0;
  bit done = 1'b0;
  logic [7:0] exp_mem [1024];

  always #4 clk = ~clk;

  // Protection model: odd addresses are protected while prot_on is set.
  assign addr_writable = !(prot_on && next_addr[0]);

  pgwr_engine #(.ADDR_W(10), .DATA_W(8), .PAGE_BYTES(32), .CYCLE_CLKS(CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_start(addr_start),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
    .next_addr(next_addr), .addr_writable(addr_writable), .cs_rise(cs_rise),
    .cs_aligned(cs_aligned), .wel(wel), .busy(busy), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .wel_clr(wel_clr),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  typedef struct packed {
    logic [9:0] addr;
    logic [6:0] n;
    logic       al;
    logic       wl;
    logic       pr;
    logic [7:0] seed;
    logic [3:0] tag;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{10'h010, 7'd4,  1'b1, 1'b1, 1'b0, 8'h11, 4'd2},   // R2 plain
    '{10'h03E, 7'd4,  1'b1, 1'b1, 1'b0, 8'h40, 4'd2},   // R2 wrap at page edge
    '{10'h045, 7'd35, 1'b1, 1'b1, 1'b0, 8'h80, 4'd3},   // R3 overwrite
    '{10'h080, 7'd5,  1'b0, 1'b1, 1'b0, 8'hA1, 4'd4},   // R4 misaligned
    '{10'h0A0, 7'd3,  1'b1, 1'b0, 1'b0, 8'hB2, 4'd5},   // R5 latch clear
    '{10'h100, 7'd6,  1'b1, 1'b1, 1'b1, 8'hC3, 4'd8},   // R8 protected slots
    '{10'h1F0, 7'd0,  1'b1, 1'b1, 1'b0, 8'h00, 4'd4},   // R4 no bytes
    '{10'h3FC, 7'd8,  1'b1, 1'b1, 1'b0, 8'hD4, 4'd2}    // R2 top page wrap
  };

  function automatic string tag_of(input int t);
    case (t)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  always @(negedge clk) if (rst_n && arr_we && !busy) stray++;

  task automatic load_addr(input logic [9:0] a);
    @(negedge clk); addr_load = 1'b1; addr_start = a;
    @(negedge clk); addr_load = 1'b0;
  endtask

  task automatic push_byte(input logic [7:0] d);
    @(negedge clk); byte_valid = 1'b1; byte_data = d;
    @(negedge clk); byte_valid = 1'b0;
  endtask

  // Raise chip select and observe the busy window, write strobes and latch clear.
  task automatic run_commit(input bit al, input bit wl, input bit inject,
                            output int bc, output int wes, output int clr, output int rdy);
    @(negedge clk); cs_rise = 1'b1; cs_aligned = al; wel = wl;
    @(negedge clk); cs_rise = 1'b0;
    bc = 0; wes = 0; rdy = 0;
    while (busy && bc < 1000) begin
      if (byte_ready) rdy++;
      if (arr_we) wes++;
      if (inject && bc == 10) begin
        byte_valid = 1'b1; byte_data = 8'h5A; cs_rise = 1'b1; cs_aligned = 1'b1;
        addr_load = 1'b1; addr_start = 10'h340;
      end else begin
        byte_valid = 1'b0; cs_rise = 1'b0; addr_load = 1'b0;
      end
      bc++;
      @(negedge clk);
    end
    byte_valid = 1'b0; cs_rise = 1'b0; addr_load = 1'b0;
    clr = wel_clr ? 1 : 0;
    @(negedge clk);
    if (wel_clr) clr += 2;
  endtask

  task automatic check_page(input logic [9:0] a, input string req);
    int bad; int bad_a; int bad_v; int bad_e;
    bad = 0; bad_a = 0; bad_v = 0; bad_e = 0;
    for (int s = 0; s < 32; s++) begin
      rd_addr = {a[9:5], 5'(s)};
      #0.1;
      if (rd_data !== exp_mem[rd_addr]) begin
        if (bad == 0) begin bad_a = int'(rd_addr); bad_v = int'(rd_data); bad_e = int'(exp_mem[rd_addr]); end
        bad++;
      end
    end
    chk(bad == 0, {req, " page contents"}, bad_v, bad_e);
    if (bad != 0) $display("  first mismatch at %0h", bad_a);
  endtask

  task automatic run_vector(input vec_t c);
    logic [7:0] pd [32];
    bit pv [32];
    bit pok [32];
    int off, exp_we, bc, wes, clr, rdy, nrdy;
    bit commit;
    for (int s = 0; s < 32; s++) begin pv[s] = 1'b0; pok[s] = 1'b0; pd[s] = '0; end
    prot_on = c.pr;
    load_addr(c.addr);
    chk(next_addr == c.addr, "R2 next_addr after load", int'(next_addr), int'(c.addr));
    off = int'(c.addr[4:0]);
    nrdy = 0;
    for (int k = 0; k < int'(c.n); k++) begin
      @(negedge clk);
      if (!byte_ready) nrdy++;
      byte_valid = 1'b1;
      byte_data  = c.seed + 8'(k * 3);
      pd[off] = byte_data; pv[off] = 1'b1; pok[off] = !(c.pr && (off % 2 == 1));
      off = (off + 1) % 32;
    end
    @(negedge clk); byte_valid = 1'b0;
    chk(next_addr == {c.addr[9:5], 5'(off)}, "R2 offset wraps in page",
        int'(next_addr), int'({c.addr[9:5], 5'(off)}));
    commit = c.al && c.wl && (c.n != 0);
    exp_we = 0;
    if (commit)
      for (int s = 0; s < 32; s++)
        if (pv[s] && pok[s]) begin exp_mem[{c.addr[9:5], 5'(s)}] = pd[s]; exp_we++; end
    run_commit(c.al, c.wl, 1'b0, bc, wes, clr, rdy);
    chk(bc == (commit ? CYC : 0), "R6 busy length", bc, commit ? CYC : 0);
    chk(wes == exp_we, "R8 write strobe count", wes, exp_we);
    chk(clr == (commit ? 1 : 0), "R7 latch clear pulse", clr, commit ? 1 : 0);
    chk(nrdy == 0, "R6 ready while idle", nrdy, 0);
    check_page(c.addr, tag_of(int'(c.tag)));
    wel = 1'b0;
  endtask

  initial begin
    int bc, wes, clr, rdy;
    for (int i = 0; i < 1024; i++) exp_mem[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(byte_ready == 1'b1, "R1 byte_ready", int'(byte_ready), 1);
    chk(arr_we == 1'b0 && wel_clr == 1'b0, "R1 strobes", int'({arr_we, wel_clr}), 0);
    check_page(10'h000, "R1");

    for (int v = 0; v < NV; v++) run_vector(VEC[v]);

    // R6: inputs during the busy window are ignored
    prot_on = 1'b0;
    load_addr(10'h300);
    push_byte(8'h21);
    push_byte(8'h22);
    exp_mem[10'h300] = 8'h21; exp_mem[10'h301] = 8'h22;
    run_commit(1'b1, 1'b1, 1'b1, bc, wes, clr, rdy);
    chk(bc == CYC, "R6 no restart on rise during busy", bc, CYC);
    chk(rdy == 0, "R6 byte_ready low while busy", rdy, 0);
    chk(wes == 2, "R8 strobes for two bytes", wes, 2);
    run_commit(1'b1, 1'b1, 1'b0, bc, wes, clr, rdy);
    chk(bc == 0, "R6 byte offered while busy not buffered", bc, 0);
    check_page(10'h300, "R6");
    check_page(10'h340, "R6 load ignored");

    // R10: aborted rise discards bytes but keeps offset
    load_addr(10'h200);
    push_byte(8'h31);
    push_byte(8'h32);
    run_commit(1'b0, 1'b1, 1'b0, bc, wes, clr, rdy);
    chk(bc == 0 && clr == 0, "R10 abort starts nothing", bc + clr, 0);
    chk(next_addr == 10'h202, "R10 offset kept", int'(next_addr), 10'h202);
    push_byte(8'h33);
    exp_mem[10'h202] = 8'h33;
    run_commit(1'b1, 1'b1, 1'b0, bc, wes, clr, rdy);
    chk(wes == 1, "R10 only post-abort byte programmed", wes, 1);
    check_page(10'h200, "R10");

    chk(stray == 0, "R9 write strobe outside busy", stray, 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule